// File: doc/BRIEF.md
# Zero-Crossing Gated Wiper Update Controller

This block sits between a serial command interface and the resistor switch network of a two-channel audio attenuator. For each channel it keeps a pending wiper code and decides on which clock edge that code becomes the active wiper output. When gating is switched on, a pending code waits until the channel's own zero-crossing comparator fires, so that the tap moves while no signal is across the element. If no zero crossing arrives, a fixed-length fallback window forces the change.

When gating is switched off, a new code goes straight to the output. A registered all-settled flag tells the downstream nonvolatile store sequencer when no channel has a change outstanding. The window length is a cycle-count parameter. Real silicon uses tens of milliseconds; a simulation uses a few cycles.

Top module: `zc_wiper_ctrl`

## Requirements
- R1: After synchronous reset, every wiper output equals the mute code (all ones, 63 for 6-bit codes) and `settled_o` is 1.
- R2: With `gate_en_i` = 0, a code strobed on `load_i[c]` appears on channel c's wiper on the clock edge that samples the strobe, and nothing is left pending.
- R3: With `gate_en_i` = 1 and no zero-crossing event, a code strobed on the edge at cycle L appears on the wiper exactly on edge L+WIN_CYC. The wiper holds its previous value on every edge before that.
- R4: With `gate_en_i` = 1, a zero-crossing event on `zc_evt_i[c]` while channel c is pending applies the pending code on the edge that samples the event.
- R5: A zero-crossing event on a channel with nothing pending leaves its wiper unchanged. An event sampled on the same edge as a load is ignored, and the load starts a fresh wait.
- R6: The channels are independent: a load, event or expiry on one channel never changes the other channel's wiper.
- R7: A new load on a channel that is still pending replaces the pending code and restarts that channel's window from zero.
- R8: `settled_o` goes to 0 on the edge that records a gated load and returns to 1 on the edge on which the last pending channel updates.
- R9: Clearing `gate_en_i` while a channel is pending applies its pending code on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en_i | input | 1 | 1 = defer updates to a zero crossing or window expiry |
| load_i | input | NCH | Per-channel new-code strobe, one cycle, raised at the command acknowledge |
| code_i | input | NCH*CODE_W | New codes; channel c is at bits [c*CODE_W +: CODE_W] |
| zc_evt_i | input | NCH | Per-channel zero-crossing event from the external comparators |
| wiper_o | output | NCH*CODE_W | Active wiper codes, same packing as code_i |
| settled_o | output | 1 | 1 when no channel has a pending update |

## Verification
The hardest cases to produce are the races inside one channel's wait. A zero-crossing event can land on the same edge as a load. A second load can arrive part way through a window, so the first deadline must pass with no change. Gating can be switched off while a code is still waiting. The stimulus uses a cycle counter to place each load, event and gate change on a chosen edge relative to the window. The scoreboard holds expected values tagged with the absolute cycle in which they must appear. It checks both the cycle just before each expected change and the cycle of the change.

// File: rtl/zc_wiper_pkg.sv
package zc_wiper_pkg;
  // Bits needed to count 0..n-1, never less than one.
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/zc_wiper_chan.sv
module zc_wiper_chan
  import zc_wiper_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int WIN_CYC = 1000,
  parameter logic [CODE_W-1:0] MUTE_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate_en_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              zc_evt_i,
  output logic [CODE_W-1:0] wiper_o,
  output logic              pend_o,
  output logic              pend_nxt_o
);
  localparam int CW = cnt_bits(WIN_CYC);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic              pend_q, pend_d;
  logic [CODE_W-1:0] hold_q, hold_d;
  logic [CODE_W-1:0] wiper_q, wiper_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              release_now;

  assign release_now = zc_evt_i || !gate_en_i || (cnt_q == LAST);

  always_comb begin
    pend_d  = pend_q;
    hold_d  = hold_q;
    wiper_d = wiper_q;
    cnt_d   = cnt_q;
    if (load_i) begin
      cnt_d = '0;
      if (!gate_en_i) begin
        wiper_d = code_i;
        pend_d  = 1'b0;
      end else begin
        hold_d = code_i;
        pend_d = 1'b1;
      end
    end else if (pend_q) begin
      if (release_now) begin
        wiper_d = hold_q;
        pend_d  = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      hold_q  <= MUTE_CODE;
      wiper_q <= MUTE_CODE;
      cnt_q   <= '0;
    end else begin
      pend_q  <= pend_d;
      hold_q  <= hold_d;
      wiper_q <= wiper_d;
      cnt_q   <= cnt_d;
    end
  end

  assign wiper_o    = wiper_q;
  assign pend_o     = pend_q;
  assign pend_nxt_o = pend_d;

  AST_DIRECT_APPLY: assert property (@(posedge clk) disable iff (rst)
    (load_i && !gate_en_i) |=> (wiper_q == $past(code_i)) && !pend_q); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (cnt_q <= LAST)); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !load_i && !zc_evt_i && gate_en_i && cnt_q != LAST) |=> $stable(wiper_q)); // R3
  AST_ZC_APPLY: assert property (@(posedge clk) disable iff (rst)
    (pend_q && zc_evt_i && !load_i) |=> (wiper_q == $past(hold_q)) && !pend_q); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !load_i) |=> $stable(wiper_q)); // R5
  AST_GATE_OFF_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !gate_en_i && !load_i) |=> !pend_q); // R9
endmodule

// File: rtl/zc_settle_flag.sv
module zc_settle_flag #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pend_nxt_i,
  output logic           settled_o
);
  logic settled_q;

  always_ff @(posedge clk) begin
    if (rst) settled_q <= 1'b1;
    else     settled_q <= ~|pend_nxt_i;
  end

  assign settled_o = settled_q;
endmodule

// File: rtl/zc_wiper_ctrl.sv
module zc_wiper_ctrl #(
  parameter int NCH = 2,
  parameter int CODE_W = 6,
  parameter int WIN_CYC = 1000,
  parameter logic [CODE_W-1:0] MUTE_CODE = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  gate_en_i,
  input  logic [NCH-1:0]        load_i,
  input  logic [NCH*CODE_W-1:0] code_i,
  input  logic [NCH-1:0]        zc_evt_i,
  output logic [NCH*CODE_W-1:0] wiper_o,
  output logic                  settled_o
);
  logic [NCH-1:0] pend;
  logic [NCH-1:0] pend_nxt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zc_wiper_chan #(
      .CODE_W(CODE_W),
      .WIN_CYC(WIN_CYC),
      .MUTE_CODE(MUTE_CODE)
    ) chan_i (
      .clk(clk),
      .rst(rst),
      .gate_en_i(gate_en_i),
      .load_i(load_i[c]),
      .code_i(code_i[c*CODE_W +: CODE_W]),
      .zc_evt_i(zc_evt_i[c]),
      .wiper_o(wiper_o[c*CODE_W +: CODE_W]),
      .pend_o(pend[c]),
      .pend_nxt_o(pend_nxt[c])
    );
  end

  zc_settle_flag #(.NCH(NCH)) settle_i (
    .clk(clk),
    .rst(rst),
    .pend_nxt_i(pend_nxt),
    .settled_o(settled_o)
  );

  AST_SETTLED_MATCH: assert property (@(posedge clk) disable iff (rst)
    settled_o == (pend == '0)); // R8
  AST_GATED_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (gate_en_i && |load_i) |=> !settled_o); // R8
endmodule

// File: tb/zc_wiper_ctrl_tb.sv
module zc_wiper_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int CODE_W = 6;
  localparam int WIN = 16;

  typedef struct {
    int cyc;
    int ch;
    int val;
    string req;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  logic gate_en = 1;
  logic [NCH-1:0] load = '0;
  logic [NCH*CODE_W-1:0] code = '0;
  logic [NCH-1:0] zc = '0;
  logic [NCH*CODE_W-1:0] wiper;
  logic settled;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  exp_t q[$];

  zc_wiper_ctrl #(.NCH(NCH), .CODE_W(CODE_W), .WIN_CYC(WIN)) dut_i (
    .clk(clk), .rst(rst), .gate_en_i(gate_en), .load_i(load),
    .code_i(code), .zc_evt_i(zc), .wiper_o(wiper), .settled_o(settled)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(input int k = 1);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  // ch 0/1 = wiper of that channel, ch 2 = settled flag
  task automatic expect_at(input int at, input int ch, input int val, input string req);
    exp_t e;
    e.cyc = at; e.ch = ch; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic drive_load(input int ch, input int val);
    load[ch] = 1'b1;
    code[ch*CODE_W +: CODE_W] = CODE_W'(val);
  endtask

  function automatic int observe(input int ch);
    if (ch == 2) return int'(settled);
    return int'(wiper[ch*CODE_W +: CODE_W]);
  endfunction

  // Monitor: pops every item due in this cycle; overdue items fail.
  always @(negedge clk) begin
    if (!rst) begin
      exp_t keep[$];
      keep = {};
      foreach (q[i]) begin
        if (q[i].cyc == cyc) begin
          int act;
          act = observe(q[i].ch);
          n_chk++;
          if (act != q[i].val) begin
            n_fail++;
            $display("FAIL %s cycle %0d sel %0d: actual %0d expected %0d",
                     q[i].req, cyc, q[i].ch, act, q[i].val);
          end
        end else if (q[i].cyc < cyc) begin
          n_chk++;
          n_fail++;
          $display("FAIL %s cycle %0d missed: actual none expected %0d",
                   q[i].req, q[i].cyc, q[i].val);
        end else begin
          keep.push_back(q[i]);
        end
      end
      q = keep;
    end
  end

  initial begin
    int n;
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state
    expect_at(cyc, 0, 63, "R1");
    expect_at(cyc, 1, 63, "R1");
    expect_at(cyc, 2, 1, "R1");
    tick(2);

    // R3 / R8: timeout path on channel 0
    n = cyc;
    drive_load(0, 10);
    expect_at(n + 1, 2, 0, "R8");
    expect_at(n + WIN, 0, 63, "R3");
    expect_at(n + 1 + WIN, 0, 10, "R3");
    expect_at(n + 1 + WIN, 1, 63, "R6");
    expect_at(n + 1 + WIN, 2, 1, "R8");
    tick(1);
    load = '0;
    tick(WIN + 3);

    // R4 zero crossing on ch1; R5 stray event on idle ch0; R6
    n = cyc;
    drive_load(1, 20);
    tick(1);
    load = '0;
    tick(3);
    zc = 2'b11;
    expect_at(n + 4, 1, 63, "R4");
    expect_at(n + 5, 1, 20, "R4");
    expect_at(n + 5, 0, 10, "R5");
    expect_at(n + 5, 2, 1, "R8");
    tick(1);
    zc = '0;
    tick(3);

    // R7 reload restarts the window
    n = cyc;
    drive_load(0, 30);
    tick(1);
    load = '0;
    tick(5);
    drive_load(0, 40);
    expect_at(n + 1 + WIN, 0, 10, "R7");
    expect_at(n + 6 + WIN, 0, 10, "R7");
    expect_at(n + 7 + WIN, 0, 40, "R7");
    tick(1);
    load = '0;
    tick(WIN + 4);

    // R5 event in the load cycle is ignored
    n = cyc;
    drive_load(1, 5);
    zc[1] = 1'b1;
    expect_at(n + 1, 1, 20, "R5");
    expect_at(n + 2, 1, 20, "R5");
    expect_at(n + 3, 1, 5, "R4");
    tick(1);
    load = '0;
    zc = '0;
    tick(1);
    zc[1] = 1'b1;
    tick(1);
    zc = '0;
    tick(3);

    // R2 gating off: both channels update at once
    gate_en = 0;
    n = cyc;
    drive_load(0, 50);
    drive_load(1, 51);
    expect_at(n + 1, 0, 50, "R2");
    expect_at(n + 1, 1, 51, "R2");
    expect_at(n + 1, 2, 1, "R2");
    tick(1);
    load = '0;
    tick(2);

    // R9 clearing gate flushes pending code
    gate_en = 1;
    n = cyc;
    drive_load(0, 7);
    tick(1);
    load = '0;
    tick(2);
    gate_en = 0;
    expect_at(n + 3, 0, 50, "R9");
    expect_at(n + 4, 0, 7, "R9");
    expect_at(n + 4, 2, 1, "R9");
    tick(4);

    if (q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL end: actual %0d pending items expected 0", q.size());
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule